// File: doc/BRIEF.md
# Programmable Video Sync Generator

This block produces horizontal, vertical and composite sync and blank signals for a raster display. It also produces gating, cursor and interrupt strobes. Every pulse is placed by a start count and an end count held in configuration inputs. Horizontal positions are counted in clocks within a line, numbered from 1. Vertical positions are counted in lines within a field, also numbered from 1.

A status word does three things. It starts and stops the timing chain. It selects interlaced or progressive scanning. It chooses which internal signal drives each of the four general output pins. In interlaced mode the frame has an odd number of lines. The second field begins halfway through the middle line of the frame, and a field-parity output follows the field.

A small state machine tracks the field. Its states are `FLD_HALT`, `FLD_ODD` and `FLD_EVEN`. Its transitions are named as follows:
- start: `FLD_HALT` to `FLD_ODD` when the run bit is 1.
- stop: any state to `FLD_HALT` when the run bit is 0.
- mid-frame: `FLD_ODD` to `FLD_EVEN` at the middle of line (v_total+1)/2 in interlaced mode.
- wrap: `FLD_EVEN` to `FLD_ODD` at the end of the frame.
- downgrade: `FLD_EVEN` to `FLD_ODD` as soon as interlace is switched off.

The register write port, scan test and output drive strength live outside the block.

Top module: `vidsync_gen`

## Requirements
- R1: While `clr` is high, the four pins `blank_vc`, `sync_vc`, `aux_h` and `aux_v` are low and `field_odd` is high. After `clr` falls, timing restarts from clock 1 of line 1.
- R2: The horizontal counter runs from 1 to `h_total` and then returns to 1, so the line period is `h_total` clocks. The internal horizontal blank is high while the count is in [`hbl_start`, `hbl_end`). The internal horizontal sync is high while the count is in [`hsy_start`, `hsy_end`).
- R3: In progressive mode the line counter runs from 1 to `v_total`. Vertical blank is high while the line is in [`vbl_start`, `vbl_end`), so it lasts (end-start)·`h_total` clocks. Vertical sync follows the same rule with `vsy_start` and `vsy_end`. Both repeat every `v_total`·`h_total` clocks.
- R4: The horizontal gate is high while the clock count is in [`hgt_start`, `hgt_end`). The vertical gate is high while the line is in [`vgt_start`, `vgt_end`).
- R5: Composite blank is the OR of horizontal and vertical blank. When status bit 4 is 0, composite sync is the OR of horizontal and vertical sync.
- R6: When status bit 4 is 1, composite sync changes on three kinds of line:
  - Vertical sync lines: composite sync is the inverse of a double-rate sync. The double-rate sync is high when the half-line position is in [`hsy_start`, `hsy_end`). The half-line position is the count minus `h_total`/2 in the second half of the line, and the count itself in the first half.
  - Equalizing lines: these are the `EQ_LINES` lines just before the sync start and the `EQ_LINES` lines starting at the sync end. On them composite sync is high while the half-line position is in [`hsy_start`, `hsy_start`+(`hsy_end`-`hsy_start`)/2).
  - All other lines: composite sync is plain horizontal sync.
- R7: When status bit 3 is 1 (interlaced), the second field starts at clock `h_total`/2+1 of line (v_total+1)/2. From there its field line count advances at each half-line point. Each field lasts ((v_total+1)/2−1)·`h_total`+`h_total`/2 clocks. `field_odd` is high for the first field and low for the second.
- R8: When status bit 3 is 0, `field_odd` stays high.
- R9: While status bit 10 is 0, the counters are held at their start and all four pins are low. Every pin is registered once. Take the first rising edge that samples bit 10 as 1. Horizontal sync then first appears on the (`hsy_start`+1)-th rising edge, counting that edge.
- R10: Status bits 2:0 choose the pins, listed as (`blank_vc`, `sync_vc`, `aux_h`, `aux_v`):

  | Bits 2:0 | blank_vc | sync_vc | aux_h | aux_v |
  |---|---|---|---|---|
  | 000 | composite blank | composite sync | horizontal gate | vertical gate |
  | 001 | vertical blank | composite sync | horizontal blank | vertical gate |
  | 010 | composite blank | vertical sync | horizontal gate | horizontal sync |
  | 011 | vertical blank | vertical sync | horizontal blank | horizontal sync |
  | 100 | composite blank | composite sync | cursor | vertical interrupt |
  | 101 | vertical blank | vertical sync | cursor | vertical interrupt |
  | 110 | composite blank | composite sync | horizontal blank | horizontal sync |
  | 111 | vertical blank | composite sync | horizontal gate | vertical interrupt |

- R11: The cursor is the AND of the horizontal and vertical gates. The vertical interrupt is high for the whole field line equal to `vbl_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| clr | input | 1 | Asynchronous clear, active high |
| stat | input | 12 | Status word: bits 2:0 select the pins, bit 3 selects interlace, bit 4 enables equalization and serration, bit 10 is the run bit |
| h_total | input | CW | Clocks per line |
| hbl_start | input | CW | Horizontal blank start count |
| hbl_end | input | CW | Horizontal blank end count (exclusive) |
| hsy_start | input | CW | Horizontal sync start count |
| hsy_end | input | CW | Horizontal sync end count (exclusive) |
| hgt_start | input | CW | Horizontal gate start count |
| hgt_end | input | CW | Horizontal gate end count (exclusive) |
| v_total | input | CW | Lines per frame |
| vbl_start | input | CW | Vertical blank start line |
| vbl_end | input | CW | Vertical blank end line (exclusive) |
| vsy_start | input | CW | Vertical sync start line |
| vsy_end | input | CW | Vertical sync end line (exclusive) |
| vgt_start | input | CW | Vertical gate start line |
| vgt_end | input | CW | Vertical gate end line (exclusive) |
| blank_vc | output | 1 | Vertical or composite blank |
| sync_vc | output | 1 | Vertical or composite sync |
| aux_h | output | 1 | Horizontal blank, horizontal gate or cursor |
| aux_v | output | 1 | Horizontal sync, vertical gate or vertical interrupt |
| field_odd | output | 1 | High in the first field, low in the second |

## Verification
The bench builds the block with CW=8 and EQ_LINES=2 and programs a 20-clock line and an 11-line frame. With these values a progressive frame takes 220 clocks and an interlaced field takes 110 clocks. Many frames therefore fit in a short run, and every measured width, period and per-frame high count can be worked out by hand from the requirements. The odd line count and the even line width bring the half-line field start within reach. They also bring the equalization band, which borders the sync line on both sides and is clipped by the frame end.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

    typedef enum logic [1:0] {
        FLD_HALT = 2'd0,
        FLD_ODD  = 2'd1,
        FLD_EVEN = 2'd2
    } fld_state_e;

    localparam int STAT_W    = 12;
    localparam int BIT_ILACE = 3;
    localparam int BIT_EQ    = 4;
    localparam int BIT_RUN   = 10;

    localparam logic [2:0] PM_CB_CS_HG_VG = 3'b000;
    localparam logic [2:0] PM_VB_CS_HB_VG = 3'b001;
    localparam logic [2:0] PM_CB_VS_HG_HS = 3'b010;
    localparam logic [2:0] PM_VB_VS_HB_HS = 3'b011;
    localparam logic [2:0] PM_CB_CS_CU_VI = 3'b100;
    localparam logic [2:0] PM_VB_VS_CU_VI = 3'b101;
    localparam logic [2:0] PM_CB_CS_HB_HS = 3'b110;
    localparam logic [2:0] PM_VB_CS_HG_VI = 3'b111;

    localparam int NPINS = 4;

endpackage

// File: rtl/vsg_line_timer.sv
module vsg_line_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          run,
    input  logic [CW-1:0] h_total,
    input  logic [CW-1:0] hbl_start,
    input  logic [CW-1:0] hbl_end,
    input  logic [CW-1:0] hsy_start,
    input  logic [CW-1:0] hsy_end,
    input  logic [CW-1:0] hgt_start,
    input  logic [CW-1:0] hgt_end,
    output logic [CW-1:0] hcnt,
    output logic          line_end,
    output logic          mid_line,
    output logic          hblank,
    output logic          hsync,
    output logic          hgate,
    output logic          hsync_dbl,
    output logic          heq
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] half;
    logic [CW-1:0] hpos;
    logic [CW-1:0] eq_w;
    logic [CW:0]   eq_end;

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            hcnt <= ONE;
        end else if (!run || line_end) begin
            hcnt <= ONE;
        end else begin
            hcnt <= hcnt + ONE;
        end
    end

    always_comb begin
        half      = h_total >> 1;
        line_end  = run && (hcnt == h_total);
        mid_line  = run && (hcnt == half);
        hpos      = (hcnt > half) ? (hcnt - half) : hcnt;
        eq_w      = (hsy_end - hsy_start) >> 1;
        eq_end    = {1'b0, hsy_start} + {1'b0, eq_w};
        hblank    = (hcnt >= hbl_start) && (hcnt < hbl_end);
        hsync     = (hcnt >= hsy_start) && (hcnt < hsy_end);
        hgate     = (hcnt >= hgt_start) && (hcnt < hgt_end);
        hsync_dbl = (hpos >= hsy_start) && (hpos < hsy_end);
        heq       = (hpos >= hsy_start) && ({1'b0, hpos} < eq_end);
    end

endmodule

// File: rtl/vsg_field_ctl.sv
module vsg_field_ctl
    import vsg_pkg::*;
#(
    parameter int CW       = 12,
    parameter int EQ_LINES = 3
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          run_req,
    input  logic          ilace,
    input  logic          line_end,
    input  logic          mid_line,
    input  logic [CW-1:0] v_total,
    input  logic [CW-1:0] vbl_start,
    input  logic [CW-1:0] vbl_end,
    input  logic [CW-1:0] vsy_start,
    input  logic [CW-1:0] vsy_end,
    input  logic [CW-1:0] vgt_start,
    input  logic [CW-1:0] vgt_end,
    output fld_state_e    fst,
    output logic          vblank,
    output logic          vsync,
    output logic          vgate,
    output logic          vint,
    output logic          eq_band
);
    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW:0]   EQ_W = (CW+1)'(EQ_LINES);

    fld_state_e    fst_d;
    logic [CW-1:0] vcnt, vcnt_d;
    logic [CW-1:0] fline, fline_d;
    logic [CW:0]   fmid;
    logic          frame_end;
    logic          go_even;

    assign fmid      = ({1'b0, v_total} + (CW+1)'(1)) >> 1;
    assign frame_end = line_end && (vcnt == v_total);
    assign go_even   = ilace && ({1'b0, vcnt} == fmid) && mid_line;

    // state register
    always_ff @(posedge clk or posedge clr) begin
        if (clr) fst <= FLD_HALT;
        else     fst <= fst_d;
    end

    // next state and counter outputs
    always_comb begin
        fst_d   = fst;
        vcnt_d  = vcnt;
        fline_d = fline;
        unique case (fst)
            FLD_HALT: begin
                vcnt_d  = ONE;
                fline_d = ONE;
                if (run_req) fst_d = FLD_ODD;               // start
            end
            FLD_ODD: begin
                if (line_end) vcnt_d = frame_end ? ONE : vcnt + ONE;
                if (go_even)        fline_d = ONE;
                else if (frame_end) fline_d = ONE;
                else if (line_end)  fline_d = fline + ONE;
                if (!run_req)     fst_d = FLD_HALT;          // stop
                else if (go_even) fst_d = FLD_EVEN;          // mid-frame
            end
            FLD_EVEN: begin
                if (line_end) vcnt_d = frame_end ? ONE : vcnt + ONE;
                if (frame_end)     fline_d = ONE;
                else if (mid_line) fline_d = fline + ONE;
                if (!run_req)       fst_d = FLD_HALT;        // stop
                else if (!ilace)    fst_d = FLD_ODD;         // downgrade
                else if (frame_end) fst_d = FLD_ODD;         // wrap
            end
            default: fst_d = FLD_HALT;
        endcase
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            vcnt  <= ONE;
            fline <= ONE;
        end else begin
            vcnt  <= vcnt_d;
            fline <= fline_d;
        end
    end

    always_comb begin
        vblank  = (fline >= vbl_start) && (fline < vbl_end);
        vsync   = (fline >= vsy_start) && (fline < vsy_end);
        vgate   = (fline >= vgt_start) && (fline < vgt_end);
        vint    = (fline == vbl_start);
        eq_band = (({1'b0, fline} + EQ_W >= {1'b0, vsy_start}) && (fline < vsy_start))
               || ((fline >= vsy_end) && ({1'b0, fline} < {1'b0, vsy_end} + EQ_W));
    end

endmodule

// File: rtl/vsg_out_stage.sv
module vsg_out_stage
    import vsg_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  fld_state_e fst,
    input  logic [2:0] pin_mode,
    input  logic       eq_en,
    input  logic       hblank,
    input  logic       hsync,
    input  logic       hgate,
    input  logic       hsync_dbl,
    input  logic       heq,
    input  logic       vblank,
    input  logic       vsync,
    input  logic       vgate,
    input  logic       vint,
    input  logic       eq_band,
    output logic [NPINS-1:0] pins_q,
    output logic       field_q
);
    logic             cblank, csync, cursor;
    logic [NPINS-1:0] pins_d;

    always_comb begin
        cblank = hblank | vblank;
        if (!eq_en)      csync = hsync | vsync;
        else if (vsync)  csync = ~hsync_dbl;
        else if (eq_band) csync = heq;
        else             csync = hsync;
        cursor = hgate & vgate;
        // pins_d = {aux_v, aux_h, sync_vc, blank_vc}
        unique case (pin_mode)
            PM_CB_CS_HG_VG: pins_d = {vgate,  hgate,  csync, cblank};
            PM_VB_CS_HB_VG: pins_d = {vgate,  hblank, csync, vblank};
            PM_CB_VS_HG_HS: pins_d = {hsync,  hgate,  vsync, cblank};
            PM_VB_VS_HB_HS: pins_d = {hsync,  hblank, vsync, vblank};
            PM_CB_CS_CU_VI: pins_d = {vint,   cursor, csync, cblank};
            PM_VB_VS_CU_VI: pins_d = {vint,   cursor, vsync, vblank};
            PM_CB_CS_HB_HS: pins_d = {hsync,  hblank, csync, cblank};
            PM_VB_CS_HG_VI: pins_d = {vint,   hgate,  csync, vblank};
            default:        pins_d = '0;
        endcase
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        always_ff @(posedge clk or posedge clr) begin
            if (clr)                 pins_q[i] <= 1'b0;
            else if (fst == FLD_HALT) pins_q[i] <= 1'b0;
            else                     pins_q[i] <= pins_d[i];
        end
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) field_q <= 1'b1;
        else     field_q <= (fst != FLD_EVEN);
    end

endmodule

// File: rtl/vidsync_gen.sv
module vidsync_gen
    import vsg_pkg::*;
#(
    parameter int CW       = 12,
    parameter int EQ_LINES = 3
) (
    input  logic              clk,
    input  logic              clr,
    input  logic [STAT_W-1:0] stat,
    input  logic [CW-1:0]     h_total,
    input  logic [CW-1:0]     hbl_start,
    input  logic [CW-1:0]     hbl_end,
    input  logic [CW-1:0]     hsy_start,
    input  logic [CW-1:0]     hsy_end,
    input  logic [CW-1:0]     hgt_start,
    input  logic [CW-1:0]     hgt_end,
    input  logic [CW-1:0]     v_total,
    input  logic [CW-1:0]     vbl_start,
    input  logic [CW-1:0]     vbl_end,
    input  logic [CW-1:0]     vsy_start,
    input  logic [CW-1:0]     vsy_end,
    input  logic [CW-1:0]     vgt_start,
    input  logic [CW-1:0]     vgt_end,
    output logic              blank_vc,
    output logic              sync_vc,
    output logic              aux_h,
    output logic              aux_v,
    output logic              field_odd
);
    fld_state_e       fst;
    logic [CW-1:0]    hcnt;
    logic             run;
    logic             line_end, mid_line;
    logic             hblank, hsync, hgate, hsync_dbl, heq;
    logic             vblank, vsync, vgate, vint, eq_band;
    logic [NPINS-1:0] pins_q;

    assign run = (fst != FLD_HALT);

    vsg_line_timer #(.CW(CW)) u_line (
        .clk(clk), .clr(clr), .run(run), .h_total(h_total),
        .hbl_start(hbl_start), .hbl_end(hbl_end),
        .hsy_start(hsy_start), .hsy_end(hsy_end),
        .hgt_start(hgt_start), .hgt_end(hgt_end),
        .hcnt(hcnt), .line_end(line_end), .mid_line(mid_line),
        .hblank(hblank), .hsync(hsync), .hgate(hgate),
        .hsync_dbl(hsync_dbl), .heq(heq)
    );

    vsg_field_ctl #(.CW(CW), .EQ_LINES(EQ_LINES)) u_field (
        .clk(clk), .clr(clr), .run_req(stat[BIT_RUN]), .ilace(stat[BIT_ILACE]),
        .line_end(line_end), .mid_line(mid_line), .v_total(v_total),
        .vbl_start(vbl_start), .vbl_end(vbl_end),
        .vsy_start(vsy_start), .vsy_end(vsy_end),
        .vgt_start(vgt_start), .vgt_end(vgt_end),
        .fst(fst), .vblank(vblank), .vsync(vsync), .vgate(vgate),
        .vint(vint), .eq_band(eq_band)
    );

    vsg_out_stage u_out (
        .clk(clk), .clr(clr), .fst(fst), .pin_mode(stat[2:0]), .eq_en(stat[BIT_EQ]),
        .hblank(hblank), .hsync(hsync), .hgate(hgate), .hsync_dbl(hsync_dbl),
        .heq(heq), .vblank(vblank), .vsync(vsync), .vgate(vgate), .vint(vint),
        .eq_band(eq_band), .pins_q(pins_q), .field_q(field_odd)
    );

    assign blank_vc = pins_q[0];
    assign sync_vc  = pins_q[1];
    assign aux_h    = pins_q[2];
    assign aux_v    = pins_q[3];

endmodule

// File: rtl/vsg_checks.sv
module vsg_checks
    import vsg_pkg::*;
#(
    parameter int CW = 12
) (
    input logic              clk,
    input logic              clr,
    input logic [STAT_W-1:0] stat,
    input logic [CW-1:0]     h_total,
    input fld_state_e        fst,
    input logic [CW-1:0]     hcnt,
    input logic              blank_vc,
    input logic              sync_vc,
    input logic              aux_h,
    input logic              aux_v,
    input logic              field_odd
);
    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (clr)
        (fst == FLD_HALT) |=> (!blank_vc && !sync_vc && !aux_h && !aux_v && field_odd));

    assert_line_wrap_R2: assert property (@(posedge clk) disable iff (clr)
        (fst != FLD_HALT && hcnt == h_total) |=> (hcnt == CW'(1)));

    assert_no_even_R8: assert property (@(posedge clk) disable iff (clr)
        (!stat[BIT_ILACE]) |=> (fst != FLD_EVEN));

    assert_even_mid_R7: assert property (@(posedge clk) disable iff (clr)
        $rose(fst == FLD_EVEN) |-> ($past(hcnt) == ($past(h_total) >> 1)));

    assert_parity_out_R7: assert property (@(posedge clk) disable iff (clr)
        (fst == FLD_EVEN) |=> !field_odd);

endmodule

bind vidsync_gen vsg_checks #(.CW(CW)) u_chk (
    .clk(clk), .clr(clr), .stat(stat), .h_total(h_total), .fst(fst),
    .hcnt(hcnt), .blank_vc(blank_vc), .sync_vc(sync_vc), .aux_h(aux_h),
    .aux_v(aux_v), .field_odd(field_odd)
);

// File: tb/sim_vidsync_gen.sv
`timescale 1ns/1ps
module sim_vidsync_gen;
    localparam int CW = 8;
    localparam int EQN = 2;

    logic          clk = 1'b0;
    logic          clr = 1'b1;
    logic [11:0]   stat = '0;
    logic [CW-1:0] h_total = 8'd20, hbl_start = 8'd15, hbl_end = 8'd21;
    logic [CW-1:0] hsy_start = 8'd4, hsy_end = 8'd8, hgt_start = 8'd3, hgt_end = 8'd8;
    logic [CW-1:0] v_total = 8'd11, vbl_start = 8'd9, vbl_end = 8'd12;
    logic [CW-1:0] vsy_start = 8'd10, vsy_end = 8'd11, vgt_start = 8'd2, vgt_end = 8'd5;
    logic blank_vc, sync_vc, aux_h, aux_v, field_odd;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vidsync_gen #(.CW(CW), .EQ_LINES(EQN)) u0 (
        .clk(clk), .clr(clr), .stat(stat), .h_total(h_total),
        .hbl_start(hbl_start), .hbl_end(hbl_end), .hsy_start(hsy_start), .hsy_end(hsy_end),
        .hgt_start(hgt_start), .hgt_end(hgt_end), .v_total(v_total),
        .vbl_start(vbl_start), .vbl_end(vbl_end), .vsy_start(vsy_start), .vsy_end(vsy_end),
        .vgt_start(vgt_start), .vgt_end(vgt_end),
        .blank_vc(blank_vc), .sync_vc(sync_vc), .aux_h(aux_h), .aux_v(aux_v),
        .field_odd(field_odd)
    );

    // pin index: 0 blank_vc, 1 sync_vc, 2 aux_h, 3 aux_v, 4 field_odd
    function automatic logic pin(input int idx);
        case (idx)
            0: return blank_vc;
            1: return sync_vc;
            2: return aux_h;
            3: return aux_v;
            default: return field_odd;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic measure(input int idx, output int w, output int p);
        int n;
        while (pin(idx) != 1'b0) @(negedge clk);
        while (pin(idx) != 1'b1) @(negedge clk);
        n = 0;
        while (pin(idx) == 1'b1) begin @(negedge clk); n++; end
        w = n;
        while (pin(idx) == 1'b0) begin @(negedge clk); n++; end
        p = n;
    endtask

    task automatic count_high(input int idx, input int ncyc, output int cnt);
        cnt = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (pin(idx)) cnt++;
        end
    endtask

    // stop, apply status and vertical setup, restart and let it settle
    task automatic setup(input logic [2:0] mode, input bit ilace, input bit eq,
                         input int vbs, input int vbe, input int vss, input int vse);
        @(negedge clk);
        stat = '0;
        repeat (3) @(negedge clk);
        vbl_start = CW'(vbs); vbl_end = CW'(vbe);
        vsy_start = CW'(vss); vsy_end = CW'(vse);
        stat = {1'b0, 1'b1, 5'd0, eq, ilace, mode};
        repeat (300) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1", "pins during clear", {28'd0, aux_v, aux_h, sync_vc, blank_vc}, 0);
        check("R1", "parity during clear", int'(field_odd), 1);
    endtask

    task automatic t_horizontal;
        int w, p;
        setup(3'b011, 0, 0, 9, 12, 10, 11);
        measure(3, w, p);
        check("R2", "hsync width", w, 4);
        check("R2", "hsync period", p, 20);
        measure(2, w, p);
        check("R2", "hblank width", w, 6);
        check("R2", "hblank period", p, 20);
    endtask

    task automatic t_vertical;
        int w, p;
        setup(3'b011, 0, 0, 9, 12, 10, 11);
        measure(1, w, p);
        check("R3", "vsync width", w, 20);
        check("R3", "vsync period", p, 220);
        measure(0, w, p);
        check("R3", "vblank width", w, 60);
        check("R3", "vblank period", p, 220);
    endtask

    task automatic t_gates;
        int w, p;
        setup(3'b000, 0, 0, 9, 12, 10, 11);
        measure(2, w, p);
        check("R4", "hgate width", w, 5);
        check("R4", "hgate period", p, 20);
        measure(3, w, p);
        check("R4", "vgate width", w, 60);
    endtask

    task automatic t_composite;
        int c;
        setup(3'b000, 0, 0, 9, 12, 10, 11);
        count_high(0, 220, c);
        check("R5", "cblank high clocks per frame", c, 108);
        count_high(1, 220, c);
        check("R5", "csync high clocks per frame", c, 60);
    endtask

    task automatic t_equalize;
        int c;
        setup(3'b000, 0, 1, 9, 12, 10, 11);
        count_high(1, 220, c);
        check("R6", "csync with serration high clocks", c, 52);
        count_high(0, 220, c);
        check("R6", "cblank unchanged by equalization", c, 108);
    endtask

    task automatic t_cursor;
        int c, w, p;
        setup(3'b100, 0, 0, 9, 12, 10, 11);
        count_high(2, 220, c);
        check("R11", "cursor high clocks per frame", c, 15);
        measure(3, w, p);
        check("R11", "vint width", w, 20);
        check("R11", "vint period", p, 220);
    endtask

    task automatic t_progressive;
        int c;
        setup(3'b011, 0, 0, 9, 12, 10, 11);
        count_high(4, 220, c);
        check("R8", "parity high clocks progressive", c, 220);
    endtask

    task automatic t_interlace;
        int w, p;
        setup(3'b011, 1, 0, 1, 3, 2, 3);
        measure(1, w, p);
        check("R7", "field vsync width", w, 20);
        check("R7", "field vsync period A", p, 110);
        measure(1, w, p);
        check("R7", "field vsync period B", p, 110);
        measure(4, w, p);
        check("R7", "odd field length", w, 110);
        check("R7", "frame length", p, 220);
    endtask

    task automatic t_run_bit;
        int c, k;
        @(negedge clk);
        stat = 12'h003;
        vbl_start = 8'd9; vbl_end = 8'd12; vsy_start = 8'd10; vsy_end = 8'd11;
        @(negedge clk);
        c = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (blank_vc || sync_vc || aux_h || aux_v) c++;
        end
        check("R9", "pin activity while stopped", c, 0);
        stat = 12'h403;
        k = 0;
        do begin
            @(posedge clk); k++;
            @(negedge clk);
        end while (!aux_v && k < 100);
        check("R9", "edges to first hsync", k, 5);
    endtask

    task automatic t_modes;
        int w, p, c;
        setup(3'b010, 0, 0, 9, 12, 10, 11);
        measure(1, w, p);
        check("R10", "mode 010 sync_vc carries vsync", w, 20);
        measure(3, w, p);
        check("R10", "mode 010 aux_v carries hsync", w, 4);
        setup(3'b110, 0, 0, 9, 12, 10, 11);
        count_high(1, 220, c);
        check("R10", "mode 110 sync_vc carries csync", c, 60);
        setup(3'b001, 0, 0, 9, 12, 10, 11);
        measure(0, w, p);
        check("R10", "mode 001 blank_vc carries vblank", w, 60);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        clr = 1'b0;
        t_horizontal();
        t_vertical();
        t_gates();
        t_composite();
        t_equalize();
        t_cursor();
        t_progressive();
        t_interlace();
        t_run_bit();
        t_modes();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule